// File: doc/BRIEF.md
# Control Endpoint Setup Receive Handshake

This block is the receive half of a USB device control endpoint. A packet layer upstream decodes tokens, delivers data bytes one per cycle and reports the end of each data packet with a CRC verdict. The block decides whether to accept the packet, returns a one-cycle ACK or NAK pulse, and stores accepted payloads in an 8-byte single-buffer FIFO.

Firmware sees two sticky status flags: one for a received setup packet and one for received OUT data. It also sees the byte count of the last accepted packet, a data port that returns the FIFO bytes in order, and an interrupt that is pending while either flag is set. A setup packet is never refused. OUT data is refused while firmware still owns either received payload, so unread bytes are never overwritten by an OUT packet. The accept or refuse decision for an OUT packet is made when its token arrives. The packet layer raises the end-of-packet strobe in a cycle after the last data byte.

Top module: `ctl_ep_rx`

## Requirements
- R1: A SETUP packet whose CRC is good is always answered with ACK, whatever the flags. It overwrites the FIFO and count and sets the setup flag.
- R2: An OUT packet whose token arrives while the setup flag is set is answered with NAK. The FIFO contents and the count are unchanged.
- R3: An OUT packet whose token arrives while the OUT-data flag is set is answered with NAK. The FIFO contents and the count are unchanged.
- R4: An OUT packet with a good CRC, whose token arrives while both flags are clear, is answered with ACK. Its bytes are stored in arrival order, the count equals its length (0 to 8), and the OUT-data flag is set.
- R5: After reset both flags and the count are zero. A flag falls only on a firmware clear pulse for that flag. If hardware sets a flag in the same cycle as its clear, the flag stays set. FIFO reads never change the flags.
- R6: The interrupt output is high exactly while at least one of the two flags is set.
- R7: A packet whose end is reported with a bad CRC gets neither ACK nor NAK. It leaves the FIFO, the count and both flags unchanged.
- R8: After each accepted packet the data port shows byte 0. Each firmware read pulse advances it to the next byte, and it wraps after the eighth byte.
- R9: The handshake is a single-cycle pulse, visible in the cycle after the end-of-packet strobe. ACK and NAK are never high together.
- R10: Bytes beyond the eighth in one packet are dropped, and the count stays at 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tok_setup_i | input | 1 | One-cycle pulse: SETUP token decoded |
| tok_out_i | input | 1 | One-cycle pulse: OUT token decoded |
| rx_vld_i | input | 1 | Data byte valid |
| rx_data_i | input | 8 | Received data byte |
| rx_end_i | input | 1 | One-cycle pulse: end of data packet |
| rx_crc_ok_i | input | 1 | CRC verdict, qualified by rx_end_i |
| hs_ack_o | output | 1 | ACK handshake pulse |
| hs_nak_o | output | 1 | NAK handshake pulse |
| fw_clr_setup_i | input | 1 | Firmware pulse: clear the setup flag |
| fw_clr_out_i | input | 1 | Firmware pulse: clear the OUT-data flag |
| fw_rd_i | input | 1 | Firmware pulse: advance the data port |
| fw_rd_data_o | output | 8 | FIFO byte at the read position |
| stat_setup_o | output | 1 | Setup-received flag |
| stat_out_o | output | 1 | OUT-data-received flag |
| stat_cnt_o | output | 4 | Byte count of the last accepted packet |
| irq_o | output | 1 | Endpoint interrupt pending |

## Verification
The bench sweeps OUT packet lengths from 0 to 8 over several byte patterns. A wrong count or an off-by-one write index would show as shifted or missing bytes on the data port. It sends OUT packets while each flag is set in turn, and sends bad-CRC SETUP and OUT packets; a design that writes straight into the FIFO or tests only one flag would lose the stored setup bytes. It also lines up a setup arrival with a firmware clear in the same cycle, where a clear-wins priority would drop a fresh setup. It sends a 10-byte packet, where an unchecked write index would wrap and overwrite the first bytes.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;
  // receive sequencer: idle, taking a setup, taking OUT data, discarding refused OUT data
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_TAKE  = 2'd2,
    ST_DROP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/ep_rst_sync.sv
module ep_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/ep_rx_ctrl.sv
module ep_rx_ctrl
  import ctl_ep_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tok_setup_i,
  input  logic tok_out_i,
  input  logic rx_vld_i,
  input  logic rx_end_i,
  input  logic crc_ok_i,
  input  logic setup_flag_i,
  input  logic out_flag_i,
  output logic restart_o,
  output logic wr_o,
  output logic commit_setup_o,
  output logic commit_out_o,
  output logic hs_ack_o,
  output logic hs_nak_o
);
  rx_state_e st_q, st_d;
  logic      ack_q, ack_d, nak_q, nak_d;
  logic      good_end;
  logic      busy;

  assign good_end = rx_end_i && crc_ok_i;
  assign busy     = setup_flag_i || out_flag_i;

  always_comb begin
    st_d = st_q;
    if (tok_setup_i)      st_d = ST_SETUP;
    else if (tok_out_i)   st_d = busy ? ST_DROP : ST_TAKE;
    else if (rx_end_i)    st_d = ST_IDLE;
  end

  always_comb begin
    commit_setup_o = good_end && (st_q == ST_SETUP);
    commit_out_o   = good_end && (st_q == ST_TAKE);
    ack_d          = commit_setup_o || commit_out_o;
    nak_d          = good_end && (st_q == ST_DROP);
    restart_o      = tok_setup_i || tok_out_i;
    wr_o           = rx_vld_i && ((st_q == ST_SETUP) || (st_q == ST_TAKE));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      ack_q <= 1'b0;
      nak_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ack_q <= ack_d;
      nak_q <= nak_d;
    end
  end

  assign hs_ack_o = ack_q;
  assign hs_nak_o = nak_q;

  // R9: a handshake only ever follows a good end-of-packet strobe
  p_hs_after_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_ack_o || hs_nak_o) |-> $past(rx_end_i && crc_ok_i));
  // R7: bad CRC is answered with silence
  p_badcrc_silent_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_end_i && !crc_ok_i) |=> (!hs_ack_o && !hs_nak_o));
  // R2, R3: an OUT token while firmware owns a payload leads to the discard state
  p_busy_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_out_i && !tok_setup_i && (setup_flag_i || out_flag_i)) |=> (st_q == ST_DROP));
endmodule

// File: rtl/ep_fifo.sv
module ep_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         restart_i,
  input  logic                         wr_i,
  input  logic [DW-1:0]                wr_data_i,
  input  logic                         commit_i,
  input  logic                         rd_i,
  output logic [DW-1:0]                rd_data_o,
  output logic [$clog2(DEPTH+1)-1:0]   cnt_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] stage_q [DEPTH];
  logic [DW-1:0] stage_d [DEPTH];
  logic [DW-1:0] mem_q   [DEPTH];
  logic [DW-1:0] mem_d   [DEPTH];
  logic [CW-1:0] widx_q, widx_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] rptr_q, rptr_d;
  logic          full;
  logic          wr_en;

  assign full  = (widx_q == CW'(DEPTH));
  assign wr_en = wr_i && !full;

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_comb begin
      stage_d[g] = (wr_en && (widx_q == CW'(g))) ? wr_data_i : stage_q[g];
      mem_d[g]   = commit_i ? stage_q[g] : mem_q[g];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[g] <= '0;
        mem_q[g]   <= '0;
      end else begin
        stage_q[g] <= stage_d[g];
        mem_q[g]   <= mem_d[g];
      end
    end

    // R7: the visible buffer moves only on a commit
    p_mem_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !commit_i |=> $stable(mem_q[g]));
  end

  always_comb begin
    widx_d = widx_q;
    if (restart_i)  widx_d = '0;
    else if (wr_en) widx_d = widx_q + 1'b1;

    cnt_d = commit_i ? widx_q : cnt_q;

    rptr_d = rptr_q;
    if (commit_i)  rptr_d = '0;
    else if (rd_i) rptr_d = (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      widx_q <= '0;
      cnt_q  <= '0;
      rptr_q <= '0;
    end else begin
      widx_q <= widx_d;
      cnt_q  <= cnt_d;
      rptr_q <= rptr_d;
    end
  end

  assign rd_data_o = mem_q[rptr_q];
  assign cnt_o     = cnt_q;

  // R10: the count never exceeds the buffer depth
  p_cnt_max_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  // R7: the count moves only on a commit
  p_cnt_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(cnt_q));
endmodule

// File: rtl/ep_flags.sv
module ep_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_setup_i,
  input  logic set_out_i,
  input  logic clr_setup_i,
  input  logic clr_out_i,
  output logic setup_o,
  output logic out_o,
  output logic irq_o
);
  logic setup_q, setup_d;
  logic out_q, out_d;

  always_comb begin
    setup_d = set_setup_i || (setup_q && !clr_setup_i);
    out_d   = set_out_i   || (out_q   && !clr_out_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      setup_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      setup_q <= setup_d;
      out_q   <= out_d;
    end
  end

  assign setup_o = setup_q;
  assign out_o   = out_q;
  assign irq_o   = setup_q || out_q;

  // R5: flags fall only on a firmware clear
  p_setup_fw_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(setup_q) |-> $past(clr_setup_i));
  p_out_fw_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_q) |-> $past(clr_out_i));
  // R5: a hardware set wins over a same-cycle clear
  p_set_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_setup_i |=> setup_q);
  // R6: the interrupt drops only after a firmware clear
  p_irq_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(clr_setup_i || clr_out_i));
endmodule

// File: rtl/ctl_ep_rx.sv
module ctl_ep_rx #(
  parameter int DEPTH       = 8,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CW         = $clog2(DEPTH+1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tok_setup_i,
  input  logic          tok_out_i,
  input  logic          rx_vld_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_end_i,
  input  logic          rx_crc_ok_i,
  output logic          hs_ack_o,
  output logic          hs_nak_o,
  input  logic          fw_clr_setup_i,
  input  logic          fw_clr_out_i,
  input  logic          fw_rd_i,
  output logic [DW-1:0] fw_rd_data_o,
  output logic          stat_setup_o,
  output logic          stat_out_o,
  output logic [CW-1:0] stat_cnt_o,
  output logic          irq_o
);
  logic rst_n;
  logic restart, wr, commit_setup, commit_out;

  ep_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  ep_rx_ctrl u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_n),
    .tok_setup_i    (tok_setup_i),
    .tok_out_i      (tok_out_i),
    .rx_vld_i       (rx_vld_i),
    .rx_end_i       (rx_end_i),
    .crc_ok_i       (rx_crc_ok_i),
    .setup_flag_i   (stat_setup_o),
    .out_flag_i     (stat_out_o),
    .restart_o      (restart),
    .wr_o           (wr),
    .commit_setup_o (commit_setup),
    .commit_out_o   (commit_out),
    .hs_ack_o       (hs_ack_o),
    .hs_nak_o       (hs_nak_o)
  );

  ep_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .restart_i (restart),
    .wr_i      (wr),
    .wr_data_i (rx_data_i),
    .commit_i  (commit_setup || commit_out),
    .rd_i      (fw_rd_i),
    .rd_data_o (fw_rd_data_o),
    .cnt_o     (stat_cnt_o)
  );

  ep_flags u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .set_setup_i (commit_setup),
    .set_out_i   (commit_out),
    .clr_setup_i (fw_clr_setup_i),
    .clr_out_i   (fw_clr_out_i),
    .setup_o     (stat_setup_o),
    .out_o       (stat_out_o),
    .irq_o       (irq_o)
  );

  // R4: the OUT-data flag rises together with an ACK
  p_out_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(stat_out_o) |-> hs_ack_o);
  // R1: the setup flag rises together with an ACK
  p_setup_ack_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(stat_setup_o) |-> hs_ack_o);
  // R9: ACK and NAK are mutually exclusive
  p_hs_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(hs_ack_o && hs_nak_o));
endmodule

// File: tb/ctl_ep_rx_tb_top.sv
module ctl_ep_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       tok_setup, tok_out, rx_vld, rx_end, rx_crc_ok;
  logic [7:0] rx_data;
  logic       hs_ack, hs_nak;
  logic       fw_clr_setup, fw_clr_out, fw_rd;
  logic [7:0] fw_rd_data;
  logic       stat_setup, stat_out, irq;
  logic [3:0] stat_cnt;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [7:0] exp_mem [8];
  int         exp_cnt;
  bit         exp_setup, exp_out;

  always #4 clk = ~clk;

  ctl_ep_rx dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .tok_setup_i    (tok_setup),
    .tok_out_i      (tok_out),
    .rx_vld_i       (rx_vld),
    .rx_data_i      (rx_data),
    .rx_end_i       (rx_end),
    .rx_crc_ok_i    (rx_crc_ok),
    .hs_ack_o       (hs_ack),
    .hs_nak_o       (hs_nak),
    .fw_clr_setup_i (fw_clr_setup),
    .fw_clr_out_i   (fw_clr_out),
    .fw_rd_i        (fw_rd),
    .fw_rd_data_o   (fw_rd_data),
    .stat_setup_o   (stat_setup),
    .stat_out_o     (stat_out),
    .stat_cnt_o     (stat_cnt),
    .irq_o          (irq)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [7:0] base, input int i);
    return base + 8'(i * 3);
  endfunction

  // full state compare; reads all eight entries so the read position returns to byte 0
  task automatic check_state(input string tag);
    chk({tag, " R5 setup flag"}, int'(stat_setup), int'(exp_setup));
    chk({tag, " R5 out flag"}, int'(stat_out), int'(exp_out));
    chk({tag, " R6 irq"}, int'(irq), int'(exp_setup || exp_out));
    chk({tag, " R4 count"}, int'(stat_cnt), exp_cnt);
    for (int i = 0; i < 8; i++) begin
      if (i < exp_cnt) chk({tag, " R8 fifo byte"}, int'(fw_rd_data), int'(exp_mem[i]));
      fw_rd = 1'b1;
      step();
      fw_rd = 1'b0;
    end
    chk({tag, " R5 flags after reads"}, int'({stat_setup, stat_out}), int'({exp_setup, exp_out}));
  endtask

  task automatic send_pkt(input bit is_setup, input int len, input logic [7:0] base,
                          input bit crc_ok, input bit clr_at_end, input string tag);
    bit exp_ack, exp_nak, take;
    if (is_setup) tok_setup = 1'b1; else tok_out = 1'b1;
    step();
    tok_setup = 1'b0;
    tok_out   = 1'b0;
    for (int i = 0; i < len; i++) begin
      rx_vld  = 1'b1;
      rx_data = pat(base, i);
      step();
    end
    rx_vld       = 1'b0;
    rx_end       = 1'b1;
    rx_crc_ok    = crc_ok;
    fw_clr_setup = clr_at_end;
    // model from the requirements, decided on the flags at token time
    take    = crc_ok && (is_setup || !(exp_setup || exp_out));
    exp_ack = take;
    exp_nak = crc_ok && !take;
    if (clr_at_end) exp_setup = 1'b0;
    if (take) begin
      for (int i = 0; i < 8; i++) if (i < len) exp_mem[i] = pat(base, i);
      exp_cnt = (len > 8) ? 8 : len;
      if (is_setup) exp_setup = 1'b1; else exp_out = 1'b1;
    end
    step();
    rx_end       = 1'b0;
    rx_crc_ok    = 1'b0;
    fw_clr_setup = 1'b0;
    chk({tag, " R9 ack"}, int'(hs_ack), int'(exp_ack));
    chk({tag, " R9 nak"}, int'(hs_nak), int'(exp_nak));
    step();
    chk({tag, " R9 single pulse"}, int'({hs_ack, hs_nak}), 0);
    check_state(tag);
  endtask

  task automatic clear(input bit s, input bit o);
    fw_clr_setup = s;
    fw_clr_out   = o;
    step();
    fw_clr_setup = 1'b0;
    fw_clr_out   = 1'b0;
    if (s) exp_setup = 1'b0;
    if (o) exp_out   = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    {tok_setup, tok_out, rx_vld, rx_end, rx_crc_ok} = '0;
    rx_data = '0;
    {fw_clr_setup, fw_clr_out, fw_rd} = '0;
    for (int i = 0; i < 8; i++) exp_mem[i] = '0;
    exp_cnt = 0; exp_setup = 0; exp_out = 0;
    repeat (3) step();
    rst_ni = 1'b1;
    repeat (4) step();

    // R5: reset state
    chk("R5 reset handshake", int'({hs_ack, hs_nak}), 0);
    check_state("R5 reset");

    // R1: setup accepted
    send_pkt(1'b1, 8, 8'h10, 1'b1, 1'b0, "R1 setup");
    // R2: OUT refused while the setup flag is set
    send_pkt(1'b0, 4, 8'h80, 1'b1, 1'b0, "R2 out during setup");
    // R7: bad CRC OUT, flags busy
    send_pkt(1'b0, 5, 8'hc0, 1'b0, 1'b0, "R7 bad crc out busy");
    clear(1'b1, 1'b0);
    check_state("R5 setup cleared");

    // R4, R3: length sweep over several patterns
    for (int rep = 0; rep < 4; rep++) begin
      for (int len = 0; len <= 8; len++) begin
        send_pkt(1'b0, len, 8'(rep * 61 + len * 17), 1'b1, 1'b0, "R4 out accept");
        send_pkt(1'b0, 3, 8'hee, 1'b1, 1'b0, "R3 out while out flag");
        clear(1'b0, 1'b1);
        check_state("R6 out cleared");
      end
    end

    // R7: bad CRC with both flags clear, OUT then SETUP
    send_pkt(1'b0, 6, 8'h33, 1'b0, 1'b0, "R7 bad crc out");
    send_pkt(1'b1, 8, 8'h44, 1'b0, 1'b0, "R7 bad crc setup");

    // R10: overlong packet
    send_pkt(1'b0, 10, 8'h5a, 1'b1, 1'b0, "R10 overlong");

    // R1: setup overrides pending OUT data; OUT flag remains
    send_pkt(1'b1, 8, 8'h21, 1'b1, 1'b0, "R1 setup over out");
    clear(1'b0, 1'b1);
    check_state("R6 setup only irq");

    // R5: same-cycle set and clear of the setup flag, set wins
    send_pkt(1'b1, 8, 8'h99, 1'b1, 1'b1, "R5 set wins");
    clear(1'b1, 1'b0);
    check_state("R5 final clear");
    send_pkt(1'b0, 2, 8'h07, 1'b1, 1'b0, "R4 out after clear");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule